// File: doc/BRIEF.md
# Banked RAM Window Controller

This block lets a processor reach a large byte memory through a small address window. The memory is split into equal banks, and the window shows one bank at a time. A bank register picks which bank that is. The processor drives a window offset, a read strobe, a write strobe and a data byte. Read data comes back registered, one cycle after the read strobe.

The highest offset of the window has two roles. A write to it loads the bank register with the data byte. In the same cycle the same byte is stored at that offset of the bank just selected. A read of that offset returns the memory byte stored there and never the bank number. The memory holds bank count times bank size bytes. Only the low bits of the 8-bit bank register needed to index the banks take part in addressing, so bank values beyond the bank count wrap round onto the physical banks.

The block has no timers and never raises an interrupt. Reset is asynchronous and active low. It is released in step with the clock by an internal two-stage synchronizer.

Top module: `bank_window_ctrl`

## Requirements
- R1: Reset sets the bank register to 0 and the read data output to 0x00, and it leaves the memory contents unchanged. After reset, accesses reach bank 0.
- R2: For any access the physical byte address is (selected bank) x BANK_BYTES + window offset. A write to any offset other than the top offset (BANK_BYTES-1) leaves the bank selection unchanged.
- R3: A write to the top offset loads the whole 8-bit data byte into the bank register, and later accesses use the new bank.
- R4: A write to the top offset also stores the same byte at the top offset of the newly selected bank, and not of the previous bank.
- R5: A read of the top offset returns the memory byte stored at that location of the current bank. The bank register value is never driven onto rdata.
- R6: rdata changes only on the clock edge at which rd_en is high, and it then shows the addressed byte. With rd_en low, rdata keeps its value, and this holds even when that location is written.
- R7: Bank value v selects physical bank v mod NUM_BANKS (NUM_BANKS a power of two, at least 2). Only the low log2(NUM_BANKS) bits of the register take part in addressing.
- R8: A write stores the byte only at the addressed location. Every other location and every read leave memory unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_ofs | input | log2(BANK_BYTES) | Byte offset within the window |
| rd_en | input | 1 | Read strobe; data appears on rdata the next cycle |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data, and the bank number when the top offset is written |
| rdata | output | 8 | Registered read data |

## Verification
The hardest state to reach from the ports is one where the bank register differs from the byte stored at the top offset of the current bank. A write-through always makes the two equal, so a read of the top offset cannot tell memory data from the bank number. The bench first leaves a non-zero byte at the top of bank 0. It then applies reset, which returns the bank register to 0 but keeps memory. A read of the top offset must then return the stored byte rather than zero. Aliasing and write-through are covered by a sweep of all 256 bank values over a small configuration, with a full readback of every bank against an arithmetic model.

// File: rtl/bw_pkg.sv
package bw_pkg;
  localparam int DATA_W = 8;
  localparam int BANK_W = 8;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/bw_rst_sync.sv
module bw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic stage1_q;
  logic stage2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= 1'b0;
      stage2_q <= 1'b0;
    end else begin
      stage1_q <= 1'b1;
      stage2_q <= stage1_q;
    end
  end

  assign rst_sync_n = stage2_q;
endmodule

// File: rtl/bw_bank_reg.sv
module bw_bank_reg
  import bw_pkg::*;
#(
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  bank_t            load_val,
  output logic [SEL_W-1:0] bank_sel
);
  bank_t bank_q;
  bank_t bank_d;

  always_comb begin
    bank_d = bank_q;
    if (load) bank_d = load_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bank_q <= '0;
    else        bank_q <= bank_d;
  end

  assign bank_sel = bank_q[SEL_W-1:0];

  // R3: a top-offset write loads the full byte into the bank register
  a_r3_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> bank_q == $past(load_val));

  // R2: no load means the bank is kept
  a_r2_bank_keep: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(bank_q));
endmodule

// File: rtl/bw_addr_gen.sv
module bw_addr_gen #(
  parameter int SEL_W = 2,
  parameter int OFS_W = 10,
  localparam int ADDR_W = SEL_W + OFS_W
) (
  input  logic [OFS_W-1:0]  win_ofs,
  input  logic              wr_en,
  input  logic [SEL_W-1:0]  bank_sel,
  input  logic [SEL_W-1:0]  wdata_sel,
  output logic              sel_hit,
  output logic [ADDR_W-1:0] mem_addr
);
  localparam logic [OFS_W-1:0] TOP_OFS = '1;

  logic [SEL_W-1:0] eff_bank;

  always_comb begin
    sel_hit  = wr_en && (win_ofs == TOP_OFS);
    eff_bank = sel_hit ? wdata_sel : bank_sel;
    mem_addr = {eff_bank, win_ofs};
  end
endmodule

// File: rtl/bw_mem.sv
module bw_mem
  import bw_pkg::*;
#(
  parameter int ADDR_W = 12,
  localparam int DEPTH = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             wdata,
  output byte_t             rdata
);
  byte_t store [DEPTH];
  byte_t rd_q;
  byte_t rd_d;

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) rd_d = store[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rdata = rd_q;

  // R6: read data only moves on a read strobe
  a_r6_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/bank_window_ctrl.sv
module bank_window_ctrl
  import bw_pkg::*;
#(
  parameter int BANK_BYTES = 1024,
  parameter int NUM_BANKS  = 4,
  localparam int OFS_W  = $clog2(BANK_BYTES),
  localparam int SEL_W  = $clog2(NUM_BANKS),
  localparam int ADDR_W = SEL_W + OFS_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFS_W-1:0] win_ofs,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata
);
  logic              rst_sync_n;
  logic              sel_hit;
  logic [SEL_W-1:0]  bank_sel;
  logic [ADDR_W-1:0] mem_addr;

  bw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bw_bank_reg #(.SEL_W(SEL_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load     (sel_hit),
    .load_val (wdata),
    .bank_sel (bank_sel)
  );

  bw_addr_gen #(.SEL_W(SEL_W), .OFS_W(OFS_W)) u_addr (
    .win_ofs   (win_ofs),
    .wr_en     (wr_en),
    .bank_sel  (bank_sel),
    .wdata_sel (wdata[SEL_W-1:0]),
    .sel_hit   (sel_hit),
    .mem_addr  (mem_addr)
  );

  bw_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .rd_en (rd_en),
    .wr_en (wr_en),
    .addr  (mem_addr),
    .wdata (wdata),
    .rdata (rdata)
  );

  // R4: a top-offset write lands in the bank named by the data byte
  a_r4_through_bank: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_hit |-> mem_addr[ADDR_W-1:OFS_W] == wdata[SEL_W-1:0]);

  // R2: other accesses use the held bank and the raw offset
  a_r2_addr_form: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !sel_hit |-> (mem_addr[ADDR_W-1:OFS_W] == bank_sel) &&
                 (mem_addr[OFS_W-1:0] == win_ofs));

  // R7: the bank used for a plain access is the one loaded last
  a_r7_bank_follow: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sel_hit |=> bank_sel == $past(wdata[SEL_W-1:0]));
endmodule

// File: tb/sim_bank_window_ctrl.sv
module sim_bank_window_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BB   = 16;
  localparam int NB   = 4;
  localparam int OW   = $clog2(BB);
  localparam int TOP  = BB - 1;
  localparam int WDOG = 50000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [OW-1:0] win_ofs = '0;
  logic          rd_en = 1'b0;
  logic          wr_en = 1'b0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [7:0] model [NB*BB];
  int         mbank = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bank_window_ctrl #(.BANK_BYTES(BB), .NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .win_ofs(win_ofs), .rd_en(rd_en),
    .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
  );

  function automatic int idx(int b, int o);
    return (b % NB) * BB + o;
  endfunction

  function automatic logic [7:0] pat(int b, int o);
    return 8'((b * 37 + o * 5 + 1) & 8'hff);
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic do_write(int o, logic [7:0] d);
    @(negedge clk);
    win_ofs = OW'(o); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    if (o == TOP) mbank = int'(d);
    model[idx(mbank, o)] = d;
  endtask

  task automatic do_read(int o, output logic [7:0] d);
    @(negedge clk);
    win_ofs = OW'(o); rd_en = 1'b1;
    @(negedge clk);
    d = rdata;
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mbank = 0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] held;
    do_reset();
    check("R1 rdata after reset", rdata, 8'h00);

    // fill every bank
    for (int b = 0; b < NB; b++) begin
      do_write(TOP, 8'(b));
      for (int o = 0; o < TOP; o++) do_write(o, pat(b, o));
    end

    // R2 / R4: full readback
    for (int b = 0; b < NB; b++) begin
      do_write(TOP, 8'(b));
      for (int o = 0; o < BB; o++) begin
        do_read(o, v);
        check("R2 readback", v, model[idx(b, o)]);
      end
    end

    // R3 / R7: sweep all bank byte values
    for (int x = 0; x < 256; x++) begin
      do_write(TOP, 8'(x));
      do_read(0, v);
      check("R3 R7 bank sweep offset 0", v, model[idx(x, 0)]);
      do_read(TOP, v);
      check("R4 top written through", v, 8'(x));
    end

    // R4: through-write hits new bank, old bank top untouched
    do_write(TOP, 8'h02);
    do_write(TOP, 8'h85);
    do_write(TOP, 8'h02);
    do_read(TOP, v);
    check("R4 old bank top keeps own value", v, 8'h02);
    do_write(TOP, 8'h85);
    do_read(TOP, v);
    check("R4 new bank top holds byte", v, 8'h85);

    // R2: non-top write keeps bank; R8 neighbours untouched
    do_write(5, 8'hAA);
    do_read(3, v);
    check("R2 bank kept after plain write", v, model[idx(1, 3)]);
    do_read(5, v);
    check("R8 written byte", v, 8'hAA);
    do_read(6, v);
    check("R8 neighbour unchanged", v, model[idx(1, 6)]);
    for (int b = 0; b < NB; b++) begin
      if (b != 1) begin
        do_write(TOP, 8'(b));
        do_read(5, v);
        check("R8 other banks unchanged", v, model[idx(b, 5)]);
      end
    end

    // R6: hold without read strobe
    do_write(TOP, 8'h01);
    do_read(7, held);
    check("R6 read value", held, model[idx(1, 7)]);
    repeat (3) @(negedge clk);
    check("R6 held idle", rdata, held);
    do_write(7, 8'h5C);
    check("R6 held across write", rdata, held);
    do_read(7, v);
    check("R6 new read", v, 8'h5C);
    do_read(7, v);
    check("R8 read does not modify", v, 8'h5C);

    // R5 / R1: bank 0 top nonzero, reset, read top
    do_write(TOP, 8'hC0);
    do_write(2, 8'h39);
    do_reset();
    check("R1 rdata cleared by reset", rdata, 8'h00);
    do_read(TOP, v);
    check("R5 top read gives memory not bank", v, 8'hC0);
    do_read(2, v);
    check("R1 bank 0 after reset, memory kept", v, 8'h39);
    do_read(9, v);
    check("R1 memory kept", v, model[idx(0, 9)]);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule